// File: doc/BRIEF.md
# Lane-Split Low-Half Interleave Unit

This block is a vector datapath stage that merges two source vectors by interleaving their low-half elements. The vector is cut into 128-bit lanes. Each lane is handled on its own: the lower half of that lane's elements in source 1 are paired with the matching elements in source 2, alternating, to fill the whole lane. The upper half of each lane of both sources plays no part in the result.

After the interleave, a per-element write mask selects which results reach the destination. Unselected elements either keep the old destination value (merge) or become zero (zero mode). Destination bits beyond the active vector length are cleared in the three-operand mode. Two two-operand modes take the old destination as the first source and keep the upper destination bits untouched. The 128-bit variant keeps bits above 127; the 64-bit variant uses only 32 bits of each source and keeps bits above 63. Source 2 may be broadcast from its lowest 32-bit or 64-bit element. Settings with no defined meaning are flagged and leave the destination unchanged.

The result can be taken straight from the logic or through one register stage with a valid flag. Decode, operand fetch and fault reporting are done by the surrounding pipeline.

Top module: `simd_unpack_lo`

## Requirements
- R1: Element size is chosen by `esize_sel_i`: 0 = 8 bits, 1 = 16, 2 = 32, 3 = 64. In every 128-bit lane, output element 2k equals source-1 element k and output element 2k+1 equals source-2 element k, for k below half the lane's element count.
- R2: Bits 127:64 of each lane of both sources have no effect on the result. For a 256-bit vector, lane 1 takes its data from source bits 191:128.
- R3: With `mask_en_i` = 1, bit j of `mask_i` governs element j counted from bit 0 of the whole vector. With `mask_en_i` = 0, every element within the active length is written.
- R4: For an element whose mask bit is 0, `zero_mode_i` = 0 keeps the old destination element and `zero_mode_i` = 1 writes zero.
- R5: With `bcast_en_i` = 1 and 32-bit or 64-bit elements, the lowest element of source 2 is copied to every element position of source 2 before the interleave.
- R6: In mode `op_mode_i` = 0 (three-operand), the active length is 128 << `vlen_sel_i` bits (`vlen_sel_i` 0, 1 or 2), and all destination bits at and above it are zero.
- R7: In mode 1 (two-operand, 128 bits), source 1 is the old destination, `src_a_i` and the mask are ignored, and destination bits above 127 keep the old destination.
- R8: In mode 2 (two-operand, 64 bits), bits 63:0 interleave the low 32 bits of the old destination and of source 2. For bytes this is {S3,D3,S2,D2,S1,D1,S0,D0}. Bits above 63 keep the old destination.
- R9: `illegal_o` = 1 and the destination equals `old_dst_i` when any of these holds: mode 3; `vlen_sel_i` = 3 in mode 0; broadcast with 8-bit or 16-bit elements; broadcast in mode 1 or 2; 64-bit elements in mode 2.
- R10: With `OUT_REG` = 1, `out_valid_o` follows `in_valid_i` one clock later and the result appears in that same cycle. While `in_valid_i` is 0, `dst_o` and `illegal_o` hold their values.
- R11: During and right after reset, with `OUT_REG` = 1, `out_valid_o`, `illegal_o` and `dst_o` are all zero.
- R12: With `OUT_REG` = 0, the outputs follow the inputs in the same cycle and `out_valid_o` equals `in_valid_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Operation present this cycle |
| op_mode_i | input | 2 | 0 three-operand, 1 two-operand 128-bit, 2 two-operand 64-bit, 3 reserved |
| vlen_sel_i | input | 2 | Active length 128 << value (mode 0) |
| esize_sel_i | input | 2 | Element size 8 << value |
| bcast_en_i | input | 1 | Broadcast lowest source-2 element |
| mask_en_i | input | 1 | Apply write mask |
| zero_mode_i | input | 1 | Masked-off elements: 1 zero, 0 keep |
| mask_i | input | MAX_BITS/8 | Per-element write mask |
| src_a_i | input | MAX_BITS | Source 1 (mode 0) |
| src_b_i | input | MAX_BITS | Source 2 |
| old_dst_i | input | MAX_BITS | Current destination value |
| out_valid_o | output | 1 | Result valid |
| illegal_o | output | 1 | Undefined setting seen |
| dst_o | output | MAX_BITS | New destination value |

## Verification
The bench builds two copies at `MAX_BITS` = 512: one with `OUT_REG` = 1 and one with `OUT_REG` = 0. Both get the same stimulus. The full 512-bit width brings all three vector lengths and all four lanes within reach, so lane-local interleave and above-length clearing can be seen in lanes 1 to 3. Comparing the copies shows that the register stage changes only timing. A sweep over every mode, length, size, broadcast and masking combination covers each reserved setting.

// File: rtl/unpk_pkg.sv
package unpk_pkg;

  localparam int LANE_BITS  = 128;
  localparam int LANE_BYTES = LANE_BITS / 8;
  localparam int NARROW_BYTES = 8;

  typedef enum logic [1:0] {
    ELEM_8  = 2'd0,
    ELEM_16 = 2'd1,
    ELEM_32 = 2'd2,
    ELEM_64 = 2'd3
  } elem_size_e;

  typedef enum logic [1:0] {
    MODE_3OP     = 2'd0,
    MODE_2OP_128 = 2'd1,
    MODE_2OP_64  = 2'd2,
    MODE_RSVD    = 2'd3
  } op_mode_e;

endpackage

// File: rtl/unpk_bcast.sv
module unpk_bcast import unpk_pkg::*; #(
  parameter int W = 512
) (
  input  logic [W-1:0] src_i,
  input  logic [1:0]   esize_i,
  input  logic         en_i,
  output logic [W-1:0] q_o
);

  localparam int CHUNKS = W / 64;

  elem_size_e esz;
  assign esz = elem_size_e'(esize_i);

  for (genvar c = 0; c < CHUNKS; c++) begin : g_chunk
    always_comb begin
      q_o[c*64 +: 64] = src_i[c*64 +: 64];
      if (en_i) begin
        if (esz == ELEM_64) begin
          q_o[c*64 +: 64] = src_i[63:0];
        end else if (esz == ELEM_32) begin
          q_o[c*64 +: 64] = {src_i[31:0], src_i[31:0]};
        end
      end
    end
  end

endmodule

// File: rtl/unpk_lane.sv
module unpk_lane import unpk_pkg::*; (
  input  logic [LANE_BITS-1:0] a_i,
  input  logic [LANE_BITS-1:0] b_i,
  input  logic [1:0]           esize_i,
  output logic [LANE_BITS-1:0] y_o
);

  logic [3:0][LANE_BITS-1:0] cand;

  for (genvar s = 0; s < 4; s++) begin : g_size
    localparam int EW   = 8 << s;
    localparam int HALF = LANE_BITS / EW / 2;
    for (genvar k = 0; k < HALF; k++) begin : g_pair
      assign cand[s][(2*k)*EW   +: EW] = a_i[k*EW +: EW];
      assign cand[s][(2*k+1)*EW +: EW] = b_i[k*EW +: EW];
    end
  end

  assign y_o = cand[esize_i];

endmodule

// File: rtl/unpk_wmask.sv
module unpk_wmask #(
  parameter int W     = 512,
  parameter int CNT_W = $clog2(W/8) + 1
) (
  input  logic [W-1:0]     res_i,
  input  logic [W-1:0]     old_i,
  input  logic [W/8-1:0]   mask_i,
  input  logic             mask_en_i,
  input  logic             zero_mode_i,
  input  logic [1:0]       esize_i,
  input  logic [CNT_W-1:0] act_bytes_i,
  input  logic             clr_above_i,
  output logic [W-1:0]     y_o
);

  localparam int NB    = W / 8;
  localparam int IDX_W = $clog2(NB);

  for (genvar g = 0; g < NB; g++) begin : g_byte
    logic [IDX_W-1:0] eidx;
    logic             in_len;
    logic             wr_ok;

    always_comb begin
      eidx   = IDX_W'(g) >> esize_i;
      in_len = CNT_W'(g) < act_bytes_i;
      wr_ok  = !mask_en_i || mask_i[eidx];
      if (!in_len) begin
        y_o[g*8 +: 8] = clr_above_i ? 8'h00 : old_i[g*8 +: 8];
      end else if (wr_ok) begin
        y_o[g*8 +: 8] = res_i[g*8 +: 8];
      end else begin
        y_o[g*8 +: 8] = zero_mode_i ? 8'h00 : old_i[g*8 +: 8];
      end
    end
  end

endmodule

// File: rtl/simd_unpack_lo.sv
module simd_unpack_lo import unpk_pkg::*; #(
  parameter int MAX_BITS = 512,
  parameter bit OUT_REG  = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid_i,
  input  logic [1:0]            op_mode_i,
  input  logic [1:0]            vlen_sel_i,
  input  logic [1:0]            esize_sel_i,
  input  logic                  bcast_en_i,
  input  logic                  mask_en_i,
  input  logic                  zero_mode_i,
  input  logic [MAX_BITS/8-1:0] mask_i,
  input  logic [MAX_BITS-1:0]   src_a_i,
  input  logic [MAX_BITS-1:0]   src_b_i,
  input  logic [MAX_BITS-1:0]   old_dst_i,
  output logic                  out_valid_o,
  output logic                  illegal_o,
  output logic [MAX_BITS-1:0]   dst_o
);

  localparam int LANES     = MAX_BITS / LANE_BITS;
  localparam int MAX_BYTES = MAX_BITS / 8;
  localparam int CNT_W     = $clog2(MAX_BYTES) + 1;

  op_mode_e   mode;
  elem_size_e esz;
  logic       two_op;
  logic       bad;
  logic [31:0]          vl_req;
  logic [CNT_W-1:0]     act_bytes;
  logic [MAX_BITS-1:0]  src1;
  logic [MAX_BITS-1:0]  src2;
  logic [MAX_BITS-1:0]  ilv;
  logic [MAX_BITS-1:0]  masked;
  logic [MAX_BITS-1:0]  res_dst;

  assign mode   = op_mode_e'(op_mode_i);
  assign esz    = elem_size_e'(esize_sel_i);
  assign two_op = (mode == MODE_2OP_128) || (mode == MODE_2OP_64);
  assign vl_req = 32'(LANE_BYTES) << vlen_sel_i;

  // setting decode: reserved encodings and length selection
  always_comb begin
    bad       = 1'b0;
    act_bytes = '0;
    unique case (mode)
      MODE_3OP: begin
        if (vl_req > 32'(MAX_BYTES)) bad = 1'b1;
        else                         act_bytes = CNT_W'(vl_req);
      end
      MODE_2OP_128: act_bytes = CNT_W'(LANE_BYTES);
      MODE_2OP_64: begin
        act_bytes = CNT_W'(NARROW_BYTES);
        if (esz == ELEM_64) bad = 1'b1;
      end
      default: bad = 1'b1;
    endcase
    if (bcast_en_i && (two_op || esz == ELEM_8 || esz == ELEM_16)) bad = 1'b1;
  end

  assign src1 = two_op ? old_dst_i : src_a_i;

  unpk_bcast #(.W(MAX_BITS)) u_bcast (
    .src_i   (src_b_i),
    .esize_i (esize_sel_i),
    .en_i    (bcast_en_i),
    .q_o     (src2)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    unpk_lane u_lane (
      .a_i     (src1[l*LANE_BITS +: LANE_BITS]),
      .b_i     (src2[l*LANE_BITS +: LANE_BITS]),
      .esize_i (esize_sel_i),
      .y_o     (ilv[l*LANE_BITS +: LANE_BITS])
    );
  end

  unpk_wmask #(.W(MAX_BITS), .CNT_W(CNT_W)) u_wmask (
    .res_i       (ilv),
    .old_i       (old_dst_i),
    .mask_i      (mask_i),
    .mask_en_i   (mask_en_i && !two_op),
    .zero_mode_i (zero_mode_i),
    .esize_i     (esize_sel_i),
    .act_bytes_i (act_bytes),
    .clr_above_i (!two_op),
    .y_o         (masked)
  );

  assign res_dst = bad ? old_dst_i : masked;

  if (OUT_REG) begin : g_reg
    logic                vld_q;
    logic                ill_q;
    logic                ill_n;
    logic [MAX_BITS-1:0] dst_q;
    logic [MAX_BITS-1:0] dst_n;

    always_comb begin
      dst_n = dst_q;
      ill_n = ill_q;
      if (in_valid_i) begin
        dst_n = res_dst;
        ill_n = bad;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        ill_q <= 1'b0;
        dst_q <= '0;
      end else begin
        vld_q <= in_valid_i;
        ill_q <= ill_n;
        dst_q <= dst_n;
      end
    end

    assign out_valid_o = vld_q;
    assign illegal_o   = ill_q;
    assign dst_o       = dst_q;
  end else begin : g_comb
    assign out_valid_o = in_valid_i;
    assign illegal_o   = bad;
    assign dst_o       = res_dst;
  end

endmodule

// File: rtl/unpk_chk.sv
module unpk_chk #(
  parameter int MAX_BITS = 512,
  parameter bit OUT_REG  = 1'b1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid_i,
  input logic [1:0]          op_mode_i,
  input logic [1:0]          vlen_sel_i,
  input logic                bcast_en_i,
  input logic [MAX_BITS-1:0] old_dst_i,
  input logic                out_valid_o,
  input logic                illegal_o,
  input logic [MAX_BITS-1:0] dst_o
);

  if (OUT_REG) begin : g_seq
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid_i |=> out_valid_o); // R10
    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid_i |=> !out_valid_o); // R10
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid_i |=> ($stable(dst_o) && $stable(illegal_o))); // R10
    AST_RSVD_KEEPS_OLD: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid_i && op_mode_i == 2'd3) |=> (illegal_o && dst_o == $past(old_dst_i))); // R9
    AST_TOP_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid_i && op_mode_i == 2'd0 && vlen_sel_i == 2'd0 && !bcast_en_i)
      |=> (!illegal_o && dst_o[MAX_BITS-1:128] == '0)); // R6
    AST_LEGACY_TOP_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid_i && op_mode_i == 2'd1 && !bcast_en_i)
      |=> (dst_o[MAX_BITS-1:128] == $past(old_dst_i[MAX_BITS-1:128]))); // R7
  end else begin : g_cmb
    AST_RSVD_KEEPS_OLD_C: assert property (@(posedge clk) disable iff (!rst_n)
      (op_mode_i == 2'd3) |-> (illegal_o && dst_o == old_dst_i)); // R9
    AST_TOP_CLEARED_C: assert property (@(posedge clk) disable iff (!rst_n)
      (op_mode_i == 2'd0 && vlen_sel_i == 2'd0 && !bcast_en_i)
      |-> (dst_o[MAX_BITS-1:128] == '0)); // R6
  end

endmodule

bind simd_unpack_lo unpk_chk #(.MAX_BITS(MAX_BITS), .OUT_REG(OUT_REG)) u_unpk_chk (.*);

// File: tb/test_simd_unpack_lo.sv
module test_simd_unpack_lo;

  logic         clk;
  logic         rst_n;
  logic         vin;
  logic [1:0]   md, vs, es;
  logic         bc, men, zm;
  logic [63:0]  m;
  logic [511:0] a, b, od;
  logic         r_vld, r_ill, c_vld, c_ill;
  logic [511:0] r_dst, c_dst;
  logic [511:0] last_exp;
  logic         last_ill;
  int nchk = 0;
  int nbad = 0;

  simd_unpack_lo #(.MAX_BITS(512), .OUT_REG(1'b1)) i_simd_unpack_lo (
    .clk(clk), .rst_n(rst_n), .in_valid_i(vin), .op_mode_i(md), .vlen_sel_i(vs),
    .esize_sel_i(es), .bcast_en_i(bc), .mask_en_i(men), .zero_mode_i(zm),
    .mask_i(m), .src_a_i(a), .src_b_i(b), .old_dst_i(od),
    .out_valid_o(r_vld), .illegal_o(r_ill), .dst_o(r_dst));

  simd_unpack_lo #(.MAX_BITS(512), .OUT_REG(1'b0)) i_simd_unpack_lo_comb (
    .clk(clk), .rst_n(rst_n), .in_valid_i(vin), .op_mode_i(md), .vlen_sel_i(vs),
    .esize_sel_i(es), .bcast_en_i(bc), .mask_en_i(men), .zero_mode_i(zm),
    .mask_i(m), .src_a_i(a), .src_b_i(b), .old_dst_i(od),
    .out_valid_o(c_vld), .illegal_o(c_ill), .dst_o(c_dst));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  initial begin
    repeat (100000) @(posedge clk);
    nchk++;
    nbad++;
    $display("watchdog expired");
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  function automatic logic [511:0] rnd512();
    logic [511:0] v;
    for (int i = 0; i < 16; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  // independent reference: loops over lanes, elements and bytes
  function automatic logic [511:0] ref_model(
    input logic [511:0] ia, input logic [511:0] ib, input logic [511:0] iod,
    input logic [1:0] ivs, input logic [1:0] ies, input logic [63:0] im,
    input logic imen, input logic izm, input logic ibc, input logic [1:0] imd,
    output logic ill);
    int eb;
    int vlb;
    logic [511:0] s1, s2, tmp, r;
    eb  = 1 << ies;
    ill = (imd == 2'd3) || (imd == 2'd0 && ivs == 2'd3) ||
          (ibc && (ies < 2'd2 || imd != 2'd0)) || (imd == 2'd2 && ies == 2'd3);
    if (ill) return iod;
    s1 = (imd == 2'd0) ? ia : iod;
    s2 = ib;
    if (ibc) for (int by = 0; by < 64; by++) s2[by*8 +: 8] = ib[(by % eb)*8 +: 8];
    vlb = (imd == 2'd0) ? (16 << ivs) : (imd == 2'd1) ? 16 : 8;
    tmp = '0;
    for (int ln = 0; ln < 4; ln++)
      for (int k = 0; k < 8 / eb; k++)
        for (int x = 0; x < eb; x++) begin
          tmp[(ln*16 + 2*k*eb + x)*8 +: 8]     = s1[(ln*16 + k*eb + x)*8 +: 8];
          tmp[(ln*16 + (2*k+1)*eb + x)*8 +: 8] = s2[(ln*16 + k*eb + x)*8 +: 8];
        end
    for (int by = 0; by < 64; by++) begin
      if (by >= vlb)
        r[by*8 +: 8] = (imd == 2'd0) ? 8'h00 : iod[by*8 +: 8];
      else if (imd != 2'd0 || !imen || im[by / eb])
        r[by*8 +: 8] = tmp[by*8 +: 8];
      else
        r[by*8 +: 8] = izm ? 8'h00 : iod[by*8 +: 8];
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [511:0] got, input logic [511:0] exp,
                     input logic gi, input logic ei);
    nchk++;
    if (got !== exp || gi !== ei) begin
      nbad++;
      $display("FAIL %s dst=%h ill=%b expected dst=%h ill=%b", tag, got, gi, exp, ei);
    end
  endtask

  task automatic chk_v(input string tag, input logic [127:0] got, input logic [127:0] exp);
    nchk++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s got=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic run_op(input string tag, input logic [511:0] ia, input logic [511:0] ib,
                        input logic [511:0] iod, input logic [1:0] ivs, input logic [1:0] ies,
                        input logic [63:0] im, input logic imen, input logic izm,
                        input logic ibc, input logic [1:0] imd);
    logic [511:0] exp;
    logic         eill;
    exp = ref_model(ia, ib, iod, ivs, ies, im, imen, izm, ibc, imd, eill);
    @(negedge clk);
    a = ia; b = ib; od = iod; vs = ivs; es = ies; m = im;
    men = imen; zm = izm; bc = ibc; md = imd; vin = 1'b1;
    #1;
    chk({tag, " comb"}, c_dst, exp, c_ill, eill);
    @(posedge clk);
    #1;
    chk(tag, r_dst, exp, r_ill, eill);
    chk_v("R10 valid", {127'd0, r_vld}, 128'd1);
    vin = 1'b0;
    last_exp = exp;
    last_ill = eill;
  endtask

  task automatic t_reset();
    chk_v("R11 valid", {127'd0, r_vld}, 128'd0);
    chk("R11", r_dst, '0, r_ill, 1'b0);
  endtask

  task automatic t_sizes();
    logic [511:0] ta, tb;
    for (int s = 0; s < 4; s++)
      run_op("R1", rnd512(), rnd512(), rnd512(), 2'd2, 2'(s), '1, 1'b0, 1'b0, 1'b0, 2'd0);
    for (int i = 0; i < 64; i++) begin
      ta[i*8 +: 8] = 8'(i);
      tb[i*8 +: 8] = 8'(8'h80 + i);
    end
    run_op("R1", ta, tb, rnd512(), 2'd0, 2'd0, '1, 1'b0, 1'b0, 1'b0, 2'd0);
    chk_v("R1 byte lane", r_dst[127:0], 128'h8707_8606_8505_8404_8303_8202_8101_8000);
  endtask

  task automatic t_upper();
    logic [511:0] ta, tb, tod, first;
    ta = rnd512(); tb = rnd512(); tod = rnd512();
    run_op("R2", ta, tb, tod, 2'd1, 2'd2, '1, 1'b0, 1'b0, 1'b0, 2'd0);
    first = r_dst;
    chk_v("R2 lane1 a", {96'd0, r_dst[159:128]}, {96'd0, ta[159:128]});
    chk_v("R2 lane1 b", {96'd0, r_dst[191:160]}, {96'd0, tb[159:128]});
    ta[127:64] = ~ta[127:64]; ta[255:192] = ~ta[255:192];
    tb[127:64] = ~tb[127:64]; tb[255:192] = ~tb[255:192];
    run_op("R2", ta, tb, tod, 2'd1, 2'd2, '1, 1'b0, 1'b0, 1'b0, 2'd0);
    chk("R2 unchanged", r_dst, first, r_ill, 1'b0);
  endtask

  task automatic t_mask();
    logic [511:0] ta, tb;
    for (int s = 0; s < 4; s++) begin
      run_op("R3", rnd512(), rnd512(), rnd512(), 2'd2, 2'(s), {$urandom, $urandom}, 1'b1, 1'b0, 1'b0, 2'd0);
      run_op("R4", rnd512(), rnd512(), rnd512(), 2'd2, 2'(s), {$urandom, $urandom}, 1'b1, 1'b1, 1'b0, 2'd0);
    end
    ta = rnd512(); tb = rnd512();
    run_op("R4", ta, tb, rnd512(), 2'd0, 2'd3, 64'h2, 1'b1, 1'b1, 1'b0, 2'd0);
    chk_v("R4 zeroed", {64'd0, r_dst[63:0]}, 128'd0);
    chk_v("R3 written", {64'd0, r_dst[127:64]}, {64'd0, tb[63:0]});
  endtask

  task automatic t_bcast();
    logic [511:0] tb;
    tb = rnd512();
    run_op("R5", rnd512(), tb, rnd512(), 2'd2, 2'd3, '1, 1'b0, 1'b0, 1'b1, 2'd0);
    chk_v("R5 qword", {r_dst[383:320], r_dst[127:64]}, {tb[63:0], tb[63:0]});
    run_op("R5", rnd512(), rnd512(), rnd512(), 2'd2, 2'd2, '1, 1'b0, 1'b0, 1'b1, 2'd0);
    run_op("R5", rnd512(), rnd512(), rnd512(), 2'd1, 2'd2, {$urandom, $urandom}, 1'b1, 1'b1, 1'b1, 2'd0);
  endtask

  task automatic t_vlen();
    for (int v = 0; v < 3; v++)
      run_op("R6", rnd512(), rnd512(), rnd512(), 2'(v), 2'd1, '1, 1'b0, 1'b0, 1'b0, 2'd0);
    run_op("R6", rnd512(), rnd512(), rnd512(), 2'd1, 2'd0, '1, 1'b1, 1'b0, 1'b0, 2'd0);
    chk("R6 top zero", {256'd0, r_dst[511:256]}, '0, 1'b0, 1'b0);
  endtask

  task automatic t_leg128();
    logic [511:0] tod;
    tod = rnd512();
    run_op("R7", rnd512(), rnd512(), tod, 2'd2, 2'd1, 64'h0, 1'b1, 1'b1, 1'b0, 2'd1);
    chk("R7 top kept", {128'd0, r_dst[511:128]}, {128'd0, tod[511:128]}, r_ill, 1'b0);
    run_op("R7", rnd512(), rnd512(), rnd512(), 2'd0, 2'd3, '1, 1'b0, 1'b0, 1'b0, 2'd1);
  endtask

  task automatic t_leg64();
    logic [511:0] tb, tod;
    tb = rnd512(); tod = rnd512();
    tb[31:0]  = 32'hA3A2_A1A0;
    tod[31:0] = 32'h1312_1110;
    run_op("R8", rnd512(), tb, tod, 2'd2, 2'd0, 64'h0, 1'b1, 1'b1, 1'b0, 2'd2);
    chk_v("R8 bytes", {64'd0, r_dst[63:0]}, {64'd0, 64'hA313_A212_A111_A010});
    chk("R8 top kept", {64'd0, r_dst[511:64]}, {64'd0, tod[511:64]}, r_ill, 1'b0);
    run_op("R8", rnd512(), rnd512(), rnd512(), 2'd0, 2'd2, '1, 1'b0, 1'b0, 1'b0, 2'd2);
  endtask

  task automatic t_illegal();
    run_op("R9", rnd512(), rnd512(), rnd512(), 2'd0, 2'd0, '1, 1'b0, 1'b0, 1'b0, 2'd3);
    run_op("R9", rnd512(), rnd512(), rnd512(), 2'd3, 2'd2, '1, 1'b0, 1'b0, 1'b0, 2'd0);
    run_op("R9", rnd512(), rnd512(), rnd512(), 2'd2, 2'd0, '1, 1'b0, 1'b0, 1'b1, 2'd0);
    run_op("R9", rnd512(), rnd512(), rnd512(), 2'd2, 2'd1, '1, 1'b0, 1'b0, 1'b1, 2'd0);
    run_op("R9", rnd512(), rnd512(), rnd512(), 2'd0, 2'd2, '1, 1'b0, 1'b0, 1'b1, 2'd1);
    run_op("R9", rnd512(), rnd512(), rnd512(), 2'd0, 2'd3, '1, 1'b0, 1'b0, 1'b0, 2'd2);
  endtask

  task automatic t_hold();
    run_op("R10", rnd512(), rnd512(), rnd512(), 2'd2, 2'd2, '1, 1'b0, 1'b0, 1'b0, 2'd0);
    @(negedge clk);
    a = rnd512(); b = rnd512(); od = rnd512(); md = 2'd3;
    repeat (2) @(posedge clk);
    #1;
    chk("R10 hold", r_dst, last_exp, r_ill, last_ill);
    chk_v("R10 valid low", {127'd0, r_vld}, 128'd0);
  endtask

  task automatic t_comb();
    logic [511:0] exp;
    logic         eill;
    @(negedge clk);
    a = rnd512(); b = rnd512(); od = rnd512(); vs = 2'd2; es = 2'd1; m = '1;
    men = 1'b0; zm = 1'b0; bc = 1'b0; md = 2'd0; vin = 1'b1;
    exp = ref_model(a, b, od, vs, es, m, men, zm, bc, md, eill);
    #1;
    chk_v("R12 valid", {127'd0, c_vld}, 128'd1);
    chk("R12", c_dst, exp, c_ill, eill);
    vin = 1'b0;
    #1;
    chk_v("R12 valid low", {127'd0, c_vld}, 128'd0);
  endtask

  task automatic t_sweep();
    string tag;
    logic  ill;
    logic [511:0] dummy;
    for (int im = 0; im < 4; im++)
      for (int iv = 0; iv < 4; iv++)
        for (int ie = 0; ie < 4; ie++)
          for (int ib = 0; ib < 2; ib++)
            for (int iz = 0; iz < 2; iz++) begin
              dummy = ref_model('0, '0, '0, 2'(iv), 2'(ie), '0, 1'b0, 1'b0, 1'(ib), 2'(im), ill);
              if (ill)          tag = "R9";
              else if (im == 1) tag = "R7";
              else if (im == 2) tag = "R8";
              else if (ib == 1) tag = "R5";
              else              tag = "R3";
              run_op(tag, rnd512(), rnd512(), rnd512(), 2'(iv), 2'(ie),
                     {$urandom, $urandom}, 1'b1, 1'(iz), 1'(ib), 2'(im));
            end
  endtask

  initial begin
    rst_n = 1'b0; vin = 1'b0; md = '0; vs = '0; es = '0;
    bc = 1'b0; men = 1'b0; zm = 1'b0; m = '0; a = '0; b = '0; od = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    t_reset();
    t_sizes();
    t_upper();
    t_mask();
    t_bcast();
    t_vlen();
    t_leg128();
    t_leg64();
    t_illegal();
    t_hold();
    t_comb();
    t_sweep();
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

endmodule